// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block sits in front of a synchronous memory array. It takes an external address and produces the address for each beat of a four-beat burst. A new burst can start from either of two load strobes. One is meant for a processor and the other for a cache controller. The processor strobe only counts while the first chip enable is active. Once a burst has started, an advance strobe steps the two low address bits, and the upper bits keep the value they were loaded with.

An order-select input picks one of two stepping orders:

- **Linear:** the low bits count up modulo four from the start value.
- **Interleaved:** each beat address is the start value XOR a beat count that runs 0, 1, 2, 3.

In both orders the fifth address equals the first. The block reports each cycle whether the address was just loaded or just advanced. Deciding between read and write, and the array itself, belong to other blocks.

Top module: `burst_addr_gen`

## Requirements
- R1: A low `rst_n` at a rising edge clears `cur_addr` to zero. It also clears `addr_loaded` and `addr_advanced` to 0.
- R2: The external address is loaded at a rising edge when all of these hold: `proc_strb_n` is 0, `ce1_n` is 0, `ce2` is 1 and `ce3_n` is 0. After that edge `cur_addr` equals the sampled `ext_addr`, `addr_loaded` is 1 and `addr_advanced` is 0.
- R3: The external address is also loaded when the processor strobe does not take effect, `ctrl_strb_n` is 0 and the chip is enabled (`ce1_n` 0, `ce2` 1, `ce3_n` 0). The outputs then behave as in R2.
- R4: While `ce1_n` is 1, `proc_strb_n` has no effect. The controller strobe and the advance strobe alone decide the cycle.
- R5: A strobe that takes effect while the chip is not enabled (`ce2` 0 or `ce3_n` 1) is a deselect cycle. `cur_addr` is held, and both flags are 0 after the edge.
- R6: When neither strobe takes effect and `adv_n` is 0, the address advances one beat. After the edge `addr_advanced` is 1 and `addr_loaded` is 0.
- R7: When neither strobe takes effect and `adv_n` is 1, `cur_addr` is held and both flags are 0.
- R8: With `order_il` = 0, each advance sets the two low bits to (start + beat) mod 4. The start value 01 gives 01, 10, 11, 00.
- R9: With `order_il` = 1, each advance sets the two low bits to start XOR beat, where beat is the count of advances since the load, modulo 4. The start value 01 gives 01, 00, 11, 10.
- R10: After four advances the low bits return to the loaded start value, in both orders.
- R11: Bits above bit 1 of `cur_addr` change only on a load. An advance never carries into them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_addr | input | AW | External start address |
| proc_strb_n | input | 1 | Processor load strobe, active low, gated by `ce1_n` |
| ctrl_strb_n | input | 1 | Controller load strobe, active low |
| adv_n | input | 1 | Burst advance strobe, active low |
| ce1_n | input | 1 | First chip enable, active low |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| order_il | input | 1 | 0 selects linear order, 1 selects interleaved order |
| cur_addr | output | AW | Current burst address |
| addr_loaded | output | 1 | Address was loaded at the last edge |
| addr_advanced | output | 1 | Address was advanced at the last edge |

## Verification
The checker watches the following on every cycle:

- the precedence between the two strobes;
- the masking of the processor strobe by the first enable;
- that an address is held on deselect and suspend cycles;
- the +1 step of the linear order;
- that the upper bits never move without a load;
- that the two flags are never set together.

The interleaved sequence depends on a beat count that is not visible at the ports. For that reason, the XOR order and the wrap after four beats are shown only by the bench. It sweeps every start value with both orders and several upper-bit patterns, and it applies all 64 strobe/enable combinations from a known mid-burst state.

// File: rtl/burst_addr_pkg.sv
// Shared types for the burst address generator.
package burst_addr_pkg;

    // Action selected for one clock cycle.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_STEP  = 2'd2,
        ACT_DESEL = 2'd3
    } burst_act_t;

endpackage

// File: rtl/burst_act_decode.sv
// Decodes the strobes and chip enables into one action per cycle.
// Precedence: the processor strobe (only while ce1_n is low) comes first,
// then the controller strobe, then the advance strobe.
// Assumes all inputs are already synchronous to the consuming clock.
module burst_act_decode
    import burst_addr_pkg::*;
(
    input  logic       proc_strb_n,
    input  logic       ctrl_strb_n,
    input  logic       adv_n,
    input  logic       ce1_n,
    input  logic       ce2,
    input  logic       ce3_n,
    output burst_act_t act
);

    logic chip_en;
    logic proc_seen;

    // The chip counts as enabled only when all three enables agree.
    assign chip_en   = !ce1_n && ce2 && !ce3_n;
    // The processor strobe is ignored while the first enable is inactive.
    assign proc_seen = !proc_strb_n && !ce1_n;

    // Priority selection of the cycle action.
    always_comb begin
        if (proc_seen) begin
            act = chip_en ? ACT_LOAD : ACT_DESEL;
        end else if (!ctrl_strb_n) begin
            act = chip_en ? ACT_LOAD : ACT_DESEL;
        end else if (!adv_n) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/burst_low_seq.sv
// Low address bits of the burst.
// Keeps the start value and a beat count separate from the address. The
// next address is start+beat (linear) or start^beat (interleaved), so
// both orders wrap back to the start after 2**BB advances.
// Assumes BB >= 1.
module burst_low_seq
    import burst_addr_pkg::*;
#(
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  burst_act_t    act,
    input  logic [BB-1:0] ext_low,
    input  logic          order_il,
    output logic [BB-1:0] low_addr
);

    logic [BB-1:0] start_q;
    logic [BB-1:0] beat_q;
    logic [BB-1:0] beat_nxt;
    logic [BB-1:0] lin_nxt;
    logic [BB-1:0] il_nxt;

    // Next beat and the linear candidate address.
    assign beat_nxt = beat_q + BB'(1);
    assign lin_nxt  = start_q + beat_nxt;

    // Interleaved candidate address, formed one bit at a time.
    for (genvar i = 0; i < BB; i++) begin : g_il_bit
        assign il_nxt[i] = start_q[i] ^ beat_nxt[i];
    end

    // Load the start value and step it by the selected order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            beat_q   <= '0;
            low_addr <= '0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    start_q  <= ext_low;
                    beat_q   <= '0;
                    low_addr <= ext_low;
                end
                ACT_STEP: begin
                    beat_q   <= beat_nxt;
                    low_addr <= order_il ? il_nxt : lin_nxt;
                end
                default: begin
                    start_q  <= start_q;
                    beat_q   <= beat_q;
                    low_addr <= low_addr;
                end
            endcase
        end
    end

endmodule

// File: rtl/burst_high_hold.sv
// Upper address bits. They change only on a load and never take a carry
// from the low bits. Assumes HW >= 1.
module burst_high_hold
    import burst_addr_pkg::*;
#(
    parameter int HW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  burst_act_t    act,
    input  logic [HW-1:0] ext_high,
    output logic [HW-1:0] high_addr
);

    // Capture the upper bits on a load and keep them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_addr <= '0;
        end else if (act == ACT_LOAD) begin
            high_addr <= ext_high;
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Top of the burst address generator: decodes the cycle action, then
// drives the low (burst) bits, the upper (held) bits and two flags that
// say whether the last edge loaded or advanced the address.
// Assumes AW > BB and BB >= 1.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int AW = 20,
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ext_addr,
    input  logic          proc_strb_n,
    input  logic          ctrl_strb_n,
    input  logic          adv_n,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          order_il,
    output logic [AW-1:0] cur_addr,
    output logic          addr_loaded,
    output logic          addr_advanced
);

    localparam int HW = AW - BB;

    burst_act_t    act;
    logic [BB-1:0] low_addr;
    logic [HW-1:0] high_addr;

    burst_act_decode u_dec (
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .adv_n       (adv_n),
        .ce1_n       (ce1_n),
        .ce2         (ce2),
        .ce3_n       (ce3_n),
        .act         (act)
    );

    burst_low_seq #(.BB(BB)) u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .ext_low  (ext_addr[BB-1:0]),
        .order_il (order_il),
        .low_addr (low_addr)
    );

    burst_high_hold #(.HW(HW)) u_high (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .ext_high  (ext_addr[AW-1:BB]),
        .high_addr (high_addr)
    );

    // Join the held upper bits and the burst bits.
    assign cur_addr = {high_addr, low_addr};

    // Register the load/advance indication for the cycle just taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_loaded   <= 1'b0;
            addr_advanced <= 1'b0;
        end else begin
            addr_loaded   <= (act == ACT_LOAD);
            addr_advanced <= (act == ACT_STEP);
        end
    end

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Cycle-by-cycle checks at the ports of burst_addr_gen, bound into it.
module burst_addr_gen_chk #(
    parameter int AW = 20,
    parameter int BB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ext_addr,
    input logic          proc_strb_n,
    input logic          ctrl_strb_n,
    input logic          adv_n,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          order_il,
    input logic [AW-1:0] cur_addr,
    input logic          addr_loaded,
    input logic          addr_advanced
);

    logic en_now;
    logic proc_now;
    logic idle_strb;

    assign en_now    = !ce1_n && ce2 && !ce3_n;
    assign proc_now  = !proc_strb_n && !ce1_n;
    assign idle_strb = !proc_now && ctrl_strb_n;

    assert_proc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(proc_now && en_now))
        |-> (cur_addr == $past(ext_addr) && addr_loaded && !addr_advanced));

    assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!proc_now && !ctrl_strb_n && en_now))
        |-> (cur_addr == $past(ext_addr) && addr_loaded));

    assert_proc_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ce1_n && ctrl_strb_n)) |-> !addr_loaded);

    assert_desel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past((proc_now || !ctrl_strb_n) && !en_now))
        |-> ($stable(cur_addr) && !addr_loaded && !addr_advanced));

    assert_step_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(idle_strb && !adv_n))
        |-> (addr_advanced && !addr_loaded));

    assert_suspend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(idle_strb && adv_n))
        |-> ($stable(cur_addr) && !addr_loaded && !addr_advanced));

    assert_linear_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(idle_strb && !adv_n && !order_il))
        |-> (cur_addr[BB-1:0] == BB'($past(cur_addr[BB-1:0]) + 1'b1)));

    assert_upper_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !addr_loaded) |-> $stable(cur_addr[AW-1:BB]));

    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_loaded, addr_advanced}));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .BB(BB)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_addr      (ext_addr),
    .proc_strb_n   (proc_strb_n),
    .ctrl_strb_n   (ctrl_strb_n),
    .adv_n         (adv_n),
    .ce1_n         (ce1_n),
    .ce2           (ce2),
    .ce3_n         (ce3_n),
    .order_il      (order_il),
    .cur_addr      (cur_addr),
    .addr_loaded   (addr_loaded),
    .addr_advanced (addr_advanced)
);

// File: tb/sim_burst_addr_gen.sv
// Self-checking bench: sweeps start values, both orders and all
// strobe/enable combinations against an arithmetic model.
module sim_burst_addr_gen;

    localparam int AW = 6;
    localparam int BB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          proc_strb_n = 1'b1;
    logic          ctrl_strb_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          ce1_n = 1'b1;
    logic          ce2 = 1'b0;
    logic          ce3_n = 1'b1;
    logic          order_il = 1'b0;
    logic [AW-1:0] cur_addr;
    logic          addr_loaded;
    logic          addr_advanced;

    int checks = 0;
    int failures = 0;

    // Model state
    logic [AW-1:0] m_addr = '0;
    int            m_start = 0;
    int            m_beat = 0;
    logic          m_ld = 1'b0;
    logic          m_adv = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen #(.AW(AW), .BB(BB)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_addr      (ext_addr),
        .proc_strb_n   (proc_strb_n),
        .ctrl_strb_n   (ctrl_strb_n),
        .adv_n         (adv_n),
        .ce1_n         (ce1_n),
        .ce2           (ce2),
        .ce3_n         (ce3_n),
        .order_il      (order_il),
        .cur_addr      (cur_addr),
        .addr_loaded   (addr_loaded),
        .addr_advanced (addr_advanced)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle, advance the model and compare all outputs.
    task automatic cyc(input logic p, input logic c, input logic a,
                       input logic e1, input logic e2, input logic e3,
                       input logic o, input logic [AW-1:0] ea);
        string tag;
        logic  en;
        int    low;
        @(negedge clk);
        proc_strb_n = p; ctrl_strb_n = c; adv_n = a;
        ce1_n = e1; ce2 = e2; ce3_n = e3; order_il = o; ext_addr = ea;
        @(posedge clk);
        #1;
        en = !e1 && e2 && !e3;
        m_ld = 1'b0; m_adv = 1'b0;
        if ((!p && !e1) || !c) begin
            if (en) begin
                m_addr = ea; m_start = int'(ea[1:0]); m_beat = 0; m_ld = 1'b1;
                tag = (!p && !e1) ? "R2" : "R3";
            end else begin
                tag = "R5";
            end
        end else if (!a) begin
            m_beat = (m_beat + 1) % 4;
            low = o ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
            m_addr = {m_addr[AW-1:BB], 2'(low)};
            m_adv = 1'b1;
            tag = (!p && e1) ? "R4" : "R6";
        end else begin
            tag = (!p && e1) ? "R4" : "R7";
        end
        chk(tag, int'(cur_addr), int'(m_addr));
        chk(tag, int'({addr_loaded, addr_advanced}), int'({m_ld, m_adv}));
    endtask

    task automatic ld(input logic [AW-1:0] ea);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, ea);
    endtask

    task automatic step(input logic o);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, o, '0);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", int'(cur_addr), 0);
        chk("R1", int'({addr_loaded, addr_advanced}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: linear sequence from 01
        ld(6'b110101);
        step(1'b0); chk("R8", int'(cur_addr[1:0]), 2);
        step(1'b0); chk("R8", int'(cur_addr[1:0]), 3);
        step(1'b0); chk("R8", int'(cur_addr[1:0]), 0);
        step(1'b0); chk("R10", int'(cur_addr[1:0]), 1);
        chk("R11", int'(cur_addr[5:2]), 13);

        // R9: interleaved sequence from 01
        ld(6'b001001);
        step(1'b1); chk("R9", int'(cur_addr[1:0]), 0);
        step(1'b1); chk("R9", int'(cur_addr[1:0]), 3);
        step(1'b1); chk("R9", int'(cur_addr[1:0]), 2);
        step(1'b1); chk("R10", int'(cur_addr[1:0]), 1);

        // Sweep all start values, both orders, several upper patterns.
        for (int u = 0; u < 16; u += 5) begin
            for (int s = 0; s < 4; s++) begin
                for (int o = 0; o < 2; o++) begin
                    ld(AW'((u << 2) | s));
                    for (int k = 0; k < 5; k++) begin
                        step(1'(o));
                        if (k == 3) chk("R10", int'(cur_addr), (u << 2) | s);
                        chk("R11", int'(cur_addr[5:2]), u);
                    end
                end
            end
        end

        // All strobe/enable combinations from a mid-burst state.
        for (int v = 0; v < 64; v++) begin
            ld(6'b101110);
            step(1'b0);
            cyc(1'(v >> 5), 1'(v >> 4), 1'(v >> 3), 1'(v >> 2), 1'(v >> 1),
                1'(v), 1'(v >> 1), 6'b010101);
        end

        // R4: masked processor strobe with controller idle, advance high
        ld(6'b000011);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'b111100);
        chk("R4", int'(cur_addr), 3);

        // R1: reset from non-zero state
        ld(6'b111111);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", int'(cur_addr), 0);
        chk("R1", int'({addr_loaded, addr_advanced}), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule